// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control core of a 14-bit successive-approximation converter that runs from its own internal clock. It watches four control inputs (chip select, convert-start, read and power-down), runs an acquisition interval, and then performs a binary search. During the search it presents a trial code to the capacitive DAC and reads back one comparator decision per bit. When the search ends it loads the result into an output latch and signals completion by releasing an active-low busy flag. The latch drives a data bus that is high-impedance unless it is selected for reading.

The convert-start pin passes through a two-stage synchronizer and an edge detector. A falling edge starts a conversion only when the sequencer is ready and chip select is low. A low level on the power-down input parks the sequencer in one of two low-power states. The chip-select level at that moment picks the state: a light nap or a deep sleep. Each state has its own wake-up count, and a start is not accepted until that count has run out. All durations are counts of internal clock cycles given as parameters.

States: ACQ (acquisition count), READY (waiting for a start), CONV (one bit per BIT_CYC cycles), DONE (result latched, busy still low), NAP, SLEEP and WAKE. The transitions are:
- ACQ→READY when the count ends.
- READY→CONV on an accepted start.
- CONV→DONE after bit 0.
- DONE→ACQ.
- ACQ/READY/WAKE→NAP or SLEEP when power-down is low.
- NAP/SLEEP→WAKE when power-down is released.
- WAKE→READY when the wake count ends.

Top module: `sarctl_top`

## Requirements
- R1: A conversion starts only on a synchronized falling edge of `cnv_n` seen in READY while `cs_n` is low. `busy_n` goes low three clock edges after `cnv_n` is driven low. With `cs_n` high the edge is ignored.
- R2: A start clears the approximation register. The first trial code on `dac_code` is 0x2000 (only bit 13 set). Bits are then decided from bit 13 down to bit 0. When `cmp_hi` is 1 (input at or above the trial) the bit is kept, otherwise it is dropped. `dac_code` is offset binary and is 0 outside a conversion.
- R3: Further `cnv_n` falling edges during a conversion neither restart it nor change its length or its result.
- R4: `busy_n` stays low for exactly 14·BIT_CYC+1 cycles. The new result appears on the output latch one cycle before `busy_n` rises.
- R5: Until that moment, the output latch keeps showing the previous result, and it shows 0 after reset.
- R6: The result is two's complement, equal to the found offset-binary code with bit 13 inverted. The most negative input gives 0x2000 and the most positive gives 0x1FFF.
- R7: `dq` is driven only while both `cs_n` and `rd_n` are low, and is high-impedance otherwise.
- R8: A low `pwr_n` in ACQ, READY or WAKE enters NAP if `cs_n` is low and SLEEP if `cs_n` is high. No start is accepted while powered down.
- R9: After `pwr_n` returns high, the sequencer spends NAP_CYC cycles (from NAP) or SLEEP_CYC cycles (from SLEEP) in WAKE before it accepts a start.
- R10: After reset and after every conversion, ACQ_CYC acquisition cycles pass during which starts are ignored.
- R11: When a start edge and a low `pwr_n` are seen in the same cycle, power-down wins and no conversion runs. A `pwr_n` low during a conversion takes effect only after the result is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select; also picks the low-power state |
| cnv_n | input | 1 | Asynchronous convert-start, falling edge active |
| rd_n | input | 1 | Active-low read enable for the data bus |
| pwr_n | input | 1 | Active-low power-down request |
| cmp_hi | input | 1 | Comparator decision for the current trial code |
| dac_code | output | 14 | Offset-binary trial code to the DAC |
| busy_n | output | 1 | Low while converting; its rising edge marks valid data |
| dq | output | 14 | Three-state two's complement result bus |

## Verification
The two functions that can fall in the same cycle are start detection and power-down entry. The bench provokes this by driving `pwr_n` low exactly two clock edges after `cnv_n` falls, so that the synchronized edge and the power-down request reach READY together. It judges the outcome from two observations: `busy_n` never falls, and the later start acceptance follows the nap wake-up count. A second case drops `pwr_n` one cycle later. Here the conversion must complete with the correct code and normal busy timing, and the sequencer must be asleep afterwards.

// File: rtl/sarctl_pkg.sv
package sarctl_pkg;

    typedef enum logic [2:0] {
        ST_ACQ,
        ST_READY,
        ST_CONV,
        ST_DONE,
        ST_NAP,
        ST_SLEEP,
        ST_WAKE
    } sar_state_e;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sarctl_start_det.sv
module sarctl_start_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cnv_n,
    output logic fall
);
    logic [STAGES:0] pipe;

    genvar g;
    generate
        for (g = 0; g <= STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[0] <= 1'b1;
                    else        pipe[0] <= cnv_n;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[g] <= 1'b1;
                    else        pipe[g] <= pipe[g-1];
                end
            end
        end
    endgenerate

    // old level high, synchronized level now low
    assign fall = pipe[STAGES] & ~pipe[STAGES-1];

endmodule

// File: rtl/sarctl_sar_core.sv
module sarctl_sar_core #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    input  logic         cmp_hi,
    output logic [W-1:0] trial,
    output logic [W-1:0] decided,
    output logic         last
);
    localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] acc;
    logic [W-1:0] mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc  <= '0;
            mask <= '0;
        end else if (clr) begin
            acc  <= '0;
            mask <= TOP_BIT;
        end else if (step) begin
            acc  <= decided;
            mask <= mask >> 1;
        end
    end

    assign trial   = acc | mask;
    assign decided = cmp_hi ? trial : acc;
    assign last    = mask[0];

endmodule

// File: rtl/sarctl_outport.sv
module sarctl_outport #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] code_ob,
    input  logic         cs_n,
    input  logic         rd_n,
    output logic [W-1:0] word,
    output logic         drv,
    output logic [W-1:0] dq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    word <= '0;
        else if (load) word <= {~code_ob[W-1], code_ob[W-2:0]};
    end

    assign drv = ~cs_n & ~rd_n;
    assign dq  = drv ? word : 'z;

endmodule

// File: rtl/sarctl_top.sv
module sarctl_top
    import sarctl_pkg::*;
#(
    parameter int W           = 14,
    parameter int BIT_CYC     = 2,
    parameter int ACQ_CYC     = 8,
    parameter int NAP_CYC     = 4,
    parameter int SLEEP_CYC   = 400000,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_n,
    input  logic         cnv_n,
    input  logic         rd_n,
    input  logic         pwr_n,
    input  logic         cmp_hi,
    output logic [W-1:0] dac_code,
    output logic         busy_n,
    output logic [W-1:0] dq
);
    localparam int unsigned CNT_MAX = max3(BIT_CYC, ACQ_CYC, max3(NAP_CYC, SLEEP_CYC, 1));
    localparam int CW = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] BIT_LAST   = CW'(BIT_CYC - 1);
    localparam logic [CW-1:0] ACQ_LAST   = CW'(ACQ_CYC - 1);
    localparam logic [CW-1:0] NAP_LAST   = CW'(NAP_CYC - 1);
    localparam logic [CW-1:0] SLEEP_LAST = CW'(SLEEP_CYC - 1);

    sar_state_e   state, state_nx;
    logic [CW-1:0] cnt;
    logic          deep_q;
    logic          start_fall;
    logic          sar_clr, sar_step, sar_last, load;
    logic [W-1:0]  trial, decided, out_word;
    logic          dq_drv;
    logic          bit_end;
    logic [CW-1:0] wake_last;
    sar_state_e    down_st;

    sarctl_start_det #(.STAGES(SYNC_STAGES)) u_start (
        .clk   (clk),
        .rst_n (rst_n),
        .cnv_n (cnv_n),
        .fall  (start_fall)
    );

    sarctl_sar_core #(.W(W)) u_sar (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (sar_clr),
        .step    (sar_step),
        .cmp_hi  (cmp_hi),
        .trial   (trial),
        .decided (decided),
        .last    (sar_last)
    );

    sarctl_outport #(.W(W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .code_ob (decided),
        .cs_n    (cs_n),
        .rd_n    (rd_n),
        .word    (out_word),
        .drv     (dq_drv),
        .dq      (dq)
    );

    assign bit_end   = (cnt == BIT_LAST);
    assign wake_last = deep_q ? SLEEP_LAST : NAP_LAST;
    assign down_st   = cs_n ? ST_SLEEP : ST_NAP;

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_ACQ: begin
                if (!pwr_n)                state_nx = down_st;
                else if (cnt == ACQ_LAST)  state_nx = ST_READY;
            end
            ST_READY: begin
                if (!pwr_n)                       state_nx = down_st;
                else if (start_fall && !cs_n)     state_nx = ST_CONV;
            end
            ST_CONV: begin
                if (bit_end && sar_last)   state_nx = ST_DONE;
            end
            ST_DONE: begin
                state_nx = ST_ACQ;
            end
            ST_NAP, ST_SLEEP: begin
                if (pwr_n)                 state_nx = ST_WAKE;
            end
            ST_WAKE: begin
                if (!pwr_n)                state_nx = down_st;
                else if (cnt == wake_last) state_nx = ST_READY;
            end
            default: state_nx = ST_ACQ;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_ACQ;
        else        state <= state_nx;
    end

    // phase timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if ((state_nx != state) || sar_step || (state == ST_READY) ||
                     (state == ST_NAP) || (state == ST_SLEEP)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // low-power flavour captured on entry
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            deep_q <= 1'b0;
        end else if ((state_nx == ST_NAP || state_nx == ST_SLEEP) && state_nx != state) begin
            deep_q <= (state_nx == ST_SLEEP);
        end
    end

    // outputs and datapath strobes
    always_comb begin
        busy_n   = 1'b1;
        dac_code = '0;
        sar_clr  = 1'b0;
        sar_step = 1'b0;
        load     = 1'b0;
        unique case (state)
            ST_READY: begin
                sar_clr = (state_nx == ST_CONV);
            end
            ST_CONV: begin
                busy_n   = 1'b0;
                dac_code = trial;
                sar_step = bit_end;
                load     = bit_end && sar_last;
            end
            ST_DONE: begin
                busy_n = 1'b0;
            end
            ST_ACQ, ST_NAP, ST_SLEEP, ST_WAKE: begin
                busy_n = 1'b1;
            end
            default: busy_n = 1'b1;
        endcase
    end

endmodule

// File: rtl/sarctl_chk.sv
module sarctl_chk
    import sarctl_pkg::*;
#(
    parameter int W         = 14,
    parameter int BIT_CYC   = 2,
    parameter int NAP_CYC   = 4,
    parameter int SLEEP_CYC = 400000
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cs_n,
    input logic         rd_n,
    input logic         busy_n,
    input logic [W-1:0] dac_code,
    input sar_state_e   state,
    input logic [W-1:0] out_word,
    input logic         oe,
    input logic         deep
);
    localparam int CONV_LEN = W * BIT_CYC + 1;
    localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

    int unsigned low_cnt;
    int unsigned wake_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt  <= 0;
            wake_cnt <= 0;
        end else begin
            low_cnt  <= busy_n ? 0 : low_cnt + 1;
            wake_cnt <= (state == ST_WAKE) ? wake_cnt + 1 : 0;
        end
    end

    assert_start_cs_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONV && $past(state) == ST_READY) |-> $past(!cs_n));

    assert_first_trial_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONV && $past(state) != ST_CONV) |-> dac_code == TOP_BIT);

    assert_no_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONV) |=> (state == ST_CONV || state == ST_DONE));

    assert_busy_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_n) |-> low_cnt == CONV_LEN);

    assert_data_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_n) |-> $stable(out_word));

    assert_hold_prev_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONV && $past(state) == ST_CONV) |-> $stable(out_word));

    assert_bus_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || rd_n) |-> !oe);

    assert_quiet_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NAP || state == ST_SLEEP) |-> (busy_n && dac_code == '0));

    assert_wake_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READY && $past(state) == ST_WAKE) |->
            wake_cnt == (deep ? SLEEP_CYC : NAP_CYC));

endmodule

bind sarctl_top sarctl_chk #(
    .W         (W),
    .BIT_CYC   (BIT_CYC),
    .NAP_CYC   (NAP_CYC),
    .SLEEP_CYC (SLEEP_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .busy_n   (busy_n),
    .dac_code (dac_code),
    .state    (state),
    .out_word (out_word),
    .oe       (dq_drv),
    .deep     (deep_q)
);

// File: tb/sarctl_top_bench.sv
module sarctl_top_bench;
    localparam int W      = 14;
    localparam int BIT    = 2;
    localparam int ACQ    = 6;
    localparam int NAP    = 4;
    localparam int SLP    = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, cnv_n = 1'b1, rd_n = 1'b1, pwr_n = 1'b1;
    logic cmp_hi;
    logic [W-1:0] dac_code;
    logic busy_n;
    wire  [W-1:0] dq;

    logic [W-1:0] tgt  = '0;
    logic [W-1:0] prev = '0;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    // behavioural comparator: offset-binary input level vs trial
    assign cmp_hi = (dac_code <= (tgt ^ 14'h2000));

    sarctl_top #(
        .W(W), .BIT_CYC(BIT), .ACQ_CYC(ACQ), .NAP_CYC(NAP), .SLEEP_CYC(SLP)
    ) u_sarctl_top (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cnv_n(cnv_n), .rd_n(rd_n),
        .pwr_n(pwr_n), .cmp_hi(cmp_hi), .dac_code(dac_code), .busy_n(busy_n), .dq(dq)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one conversion of target t; ends at the sample where busy_n has just risen
    task automatic do_conv(input logic [W-1:0] t, input bit glitch, input bit sd);
        cs_n = 1'b0; rd_n = 1'b0; tgt = t;
        @(negedge clk); cnv_n = 1'b0;
        @(negedge clk); @(negedge clk);
        chk(busy_n === 1'b1, "R1 busy still high two edges after start", 32'(busy_n), 1);
        @(negedge clk);
        chk(busy_n === 1'b0, "R1 start accepted", 32'(busy_n), 0);
        chk(dac_code === 14'h2000, "R2 first trial code", 32'(dac_code), 32'h2000);
        cnv_n = 1'b1;
        repeat (5) @(negedge clk);
        if (glitch) cnv_n = 1'b0;
        if (sd) pwr_n = 1'b0;
        repeat (3) @(negedge clk);
        cnv_n = 1'b1;
        repeat (W * BIT - 9) @(negedge clk);
        chk(busy_n === 1'b0, "R4 busy low through last bit", 32'(busy_n), 0);
        chk(dq === prev, "R5 previous result held", 32'(dq), 32'(prev));
        @(negedge clk);
        chk(busy_n === 1'b0, "R4 busy still low in final cycle", 32'(busy_n), 0);
        chk(dq === t, "R4 data present before busy rises", 32'(dq), 32'(t));
        @(negedge clk);
        chk(busy_n === 1'b1, "R4 busy rises after 14*BIT+1 cycles", 32'(busy_n), 1);
        chk(dq === t, "R6 two's complement result", 32'(dq), 32'(t));
        if (glitch) chk(dq === t, "R3 extra start edge ignored", 32'(dq), 32'(t));
        prev = t;
    endtask

    // drive a start and report whether busy_n fell; finishes any conversion
    task automatic pulse_watch(output bit seen);
        seen = 1'b0;
        cnv_n = 1'b0;
        repeat (6) begin
            @(negedge clk);
            if (busy_n === 1'b0) seen = 1'b1;
        end
        cnv_n = 1'b1;
        if (seen) begin
            while (busy_n !== 1'b1) @(negedge clk);
            prev = tgt;
        end
        repeat (ACQ + 2) @(negedge clk);
    endtask

    task automatic wake_trial(input bit deep, input int k);
        bit seen;
        int lim;
        lim = deep ? SLP : NAP;
        @(negedge clk); cs_n = deep; pwr_n = 1'b0;
        repeat (3) @(negedge clk);
        cs_n = 1'b0;
        pulse_watch(seen);
        chk(seen == 1'b0, "R8 start ignored while powered down", 32'(seen), 0);
        pwr_n = 1'b1;
        repeat (k) @(negedge clk);
        pulse_watch(seen);
        chk(seen == (k >= lim - 1), deep ? "R9 sleep wake gating" : "R9 nap wake gating",
            32'(seen), 32'(k >= lim - 1));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R4 watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        bit seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_n === 1'b1, "R5 reset busy high", 32'(busy_n), 1);
        chk(dac_code === '0, "R2 reset trial code zero", 32'(dac_code), 0);
        chk(dq === 14'bz, "R7 bus floats with cs_n high", 32'(dq), 32'h0);
        cs_n = 1'b0; rd_n = 1'b0; #1;
        chk(dq === '0, "R5 reset result zero", 32'(dq), 0);
        rd_n = 1'b1; #1;
        chk(dq === 14'bz, "R7 bus floats with rd_n high", 32'(dq), 32'h0);
        cs_n = 1'b1; rd_n = 1'b0; #1;
        chk(dq === 14'bz, "R7 bus floats with cs_n high, rd_n low", 32'(dq), 32'h0);
        repeat (ACQ + 2) @(negedge clk);

        // R6 corners
        do_conv(14'h2000, 1'b0, 1'b0); repeat (ACQ) @(negedge clk);
        do_conv(14'h1FFF, 1'b0, 1'b0); repeat (ACQ) @(negedge clk);
        do_conv(14'h0000, 1'b0, 1'b0); repeat (ACQ) @(negedge clk);
        do_conv(14'h3FFF, 1'b1, 1'b0); repeat (ACQ) @(negedge clk);
        // sweep across the code space
        for (int i = 0; i < 64; i++) begin
            do_conv(14'((i * 257 + 5) & 16'h3FFF), (i % 4) == 1, 1'b0);
            repeat (ACQ) @(negedge clk);
        end

        // R10 acquisition window
        do_conv(14'h0123, 1'b0, 1'b0);
        repeat (ACQ - 3) @(negedge clk);
        tgt = 14'h0AAA;
        pulse_watch(seen);
        chk(seen == 1'b0, "R10 start during acquisition ignored", 32'(seen), 0);
        do_conv(14'h0456, 1'b0, 1'b0);
        repeat (ACQ - 2) @(negedge clk);
        tgt = 14'h2BCD;
        pulse_watch(seen);
        chk(seen == 1'b1, "R10 start right after acquisition accepted", 32'(seen), 1);
        #1;
        chk(dq === 14'h2BCD, "R6 result of boundary start", 32'(dq), 32'h2BCD);

        // R1 chip select high blocks a start
        cs_n = 1'b1;
        pulse_watch(seen);
        chk(seen == 1'b0, "R1 start with cs_n high ignored", 32'(seen), 0);
        cs_n = 1'b0;

        // R9 wake sweeps
        for (int k = NAP - 3; k <= NAP + 1; k++) wake_trial(1'b0, k);
        for (int k = SLP - 3; k <= SLP + 1; k++) wake_trial(1'b1, k);

        // R11 start and power-down in the same cycle
        @(negedge clk); cs_n = 1'b0; cnv_n = 1'b0;
        @(negedge clk);
        @(negedge clk); pwr_n = 1'b0;
        seen = 1'b0;
        repeat (6) begin @(negedge clk); if (busy_n === 1'b0) seen = 1'b1; end
        cnv_n = 1'b1;
        chk(seen == 1'b0, "R11 power-down wins over same-cycle start", 32'(seen), 0);
        pwr_n = 1'b1;
        repeat (NAP - 1) @(negedge clk);
        pulse_watch(seen);
        chk(seen == 1'b1, "R11 nap entered, start after nap wake", 32'(seen), 1);

        // R11 power-down during a conversion
        do_conv(14'h1357, 1'b0, 1'b1);
        pulse_watch(seen);
        chk(seen == 1'b0, "R11 deferred power-down in effect after result", 32'(seen), 0);
        pwr_n = 1'b1;
        repeat (NAP + 2) @(negedge clk);
        do_conv(14'h3001, 1'b0, 1'b0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule